// File: doc/BRIEF.md
# Three-Stage Nonblocking Circuit Switch

This block is a twelve-port circuit-switched fabric built from three layers of small crossbars. Four first-layer switches each gather three input ports. Four last-layer switches each serve three output ports. Five middle switches sit between them, and each middle switch has one link to every first-layer switch and one to every last-layer switch. Because the middle layer has one switch more than the links that can be taken at a single first-layer switch and a single last-layer switch together, a path between an idle input and an idle output can always be found. Existing paths are never moved to make room.

A small controller takes one request at a time. A request is either a setup or a teardown, and it names one input port and one output port. For a setup, the controller searches for a middle switch whose link from the source first-layer switch and whose link to the destination last-layer switch are both unused. It then writes the three crosspoint settings. A teardown clears the settings and frees both links. Payload words and their valid bits then flow combinationally from each input to its connected output.

Top module: `clos_switch`

## Requirements
- R1: After reset every output has valid low and data zero, and `rsp_done` is low.
- R2: A request is accepted on a clock edge where `req_valid` is high and no other request is in progress. `rsp_done` is high for exactly the one cycle that follows the second edge after acceptance. On that cycle `rsp_err` is 0 for a setup whose ports are both idle.
- R3: Once a setup completes, output port `req_out` carries the data word and the valid bit of input port `req_in` in the same cycle they are applied.
- R4: A successful setup uses the lowest-numbered middle switch whose link from the source first-layer switch and whose link to the destination last-layer switch are both free. The number of that switch is reported on `rsp_mid`. Port k belongs to outer switch k/3.
- R5: A setup between an idle input and an idle output always succeeds, even when all other ports are connected. Every connection already in place keeps delivering its data unchanged.
- R6: A setup that names an input that is already connected, or an output that is already connected, finishes with `rsp_err` = 1 and changes no connection.
- R7: A teardown that names an existing input-to-output connection finishes with `rsp_err` = 0. The output then drives zero with valid low, and the links it held can be taken by later setups.
- R8: A teardown that names an input that is not connected to the given output finishes with `rsp_err` = 1 and changes no connection.
- R9: An output that has no connection drives zero data with valid low, whatever the inputs carry.
- R10: `req_valid` pulses that arrive while a request is in progress are ignored.
- R11: A request that names a port number of 12 or more finishes with `rsp_err` = 1 and changes no connection. On `req_kind`, 0 means setup and 1 means teardown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 1 | 0 = setup, 1 = teardown |
| req_in | input | 4 | Input port of the request |
| req_out | input | 4 | Output port of the request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request rejected (valid with rsp_done) |
| rsp_mid | output | 3 | Middle switch used (valid with rsp_done) |
| in_data | input | 96 | Twelve 8-bit payload words, port k at bits 8k+7:8k |
| in_valid | input | 12 | Payload valid per input port |
| out_data | output | 96 | Twelve 8-bit routed words, port k at bits 8k+7:8k |
| out_valid | output | 12 | Routed valid per output port |

## Verification
The hardest state to reach is a fully loaded fabric in which the middle-switch choice depends on links taken by earlier, unrelated setups. That is where the nonblocking property and the lowest-free choice matter. The bench fills all twelve ports under a sweep of twelve shifted permutations. It then tears down every odd input and reconnects those inputs to different outputs, so the links that are free become scattered. A bench-side model of link occupancy predicts every reported middle switch.

// File: rtl/clos_pkg.sv
package clos_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SRCH, ST_PROG} ctrl_st_e;

  localparam logic KIND_SETUP    = 1'b0;
  localparam logic KIND_TEARDOWN = 1'b1;

  // index width that is at least one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // outer switch that owns a port
  function automatic int sw_of(input int port, input int per_sw);
    return port / per_sw;
  endfunction

  // position of a port inside its outer switch
  function automatic int loc_of(input int port, input int per_sw);
    return port % per_sw;
  endfunction

endpackage

// File: rtl/clos_xbar.sv
module clos_xbar
  import clos_pkg::*;
#(
  parameter int NIN  = 3,
  parameter int NOUT = 5,
  parameter int W    = 8,
  localparam int SW  = idx_w(NIN),
  localparam int OW  = idx_w(NOUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OW-1:0]     wr_port,
  input  logic [SW-1:0]     wr_sel,
  input  logic              wr_on,
  input  logic [NIN*W-1:0]  in_d,
  input  logic [NIN-1:0]    in_v,
  output logic [NOUT*W-1:0] out_d,
  output logic [NOUT-1:0]   out_v
);

  logic [SW-1:0] sel_q [NOUT];
  logic [NOUT-1:0] on_q;

  for (genvar o = 0; o < NOUT; o++) begin : g_col
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_q[o] <= '0;
        on_q[o]  <= 1'b0;
      end else if (wr_en && (wr_port == OW'(o))) begin
        sel_q[o] <= wr_sel;
        on_q[o]  <= wr_on;
      end
    end
    assign out_d[o*W +: W] = on_q[o] ? in_d[sel_q[o]*W +: W] : '0;
    assign out_v[o]        = on_q[o] & in_v[sel_q[o]];
  end

endmodule

// File: rtl/clos_ctrl.sv
module clos_ctrl
  import clos_pkg::*;
#(
  parameter int NI = 4,
  parameter int NO = 4,
  parameter int N  = 3,
  parameter int P  = 3,
  parameter int M  = N + P - 1,
  localparam int PORTS = NI * N,
  localparam int PW = idx_w(PORTS),
  localparam int AW = idx_w(NI),
  localparam int BW = idx_w(NO),
  localparam int MW = idx_w(M),
  localparam int LW = idx_w(N),
  localparam int OW = idx_w(P)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_kind,
  input  logic [PW-1:0] req_in,
  input  logic [PW-1:0] req_out,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [MW-1:0] rsp_mid,
  output logic          prog_en,
  output logic          prog_on,
  output logic [AW-1:0] prog_a,
  output logic [BW-1:0] prog_b,
  output logic [MW-1:0] prog_m,
  output logic [LW-1:0] prog_li,
  output logic [OW-1:0] prog_lo
);

  ctrl_st_e st_q;
  logic          kind_q;
  logic [PW-1:0] pin_q, pout_q;
  logic          res_err_q;
  logic [MW-1:0] res_mid_q;

  logic [PORTS-1:0] in_busy, out_busy;
  logic [PW-1:0]    in_dst [PORTS];
  logic [MW-1:0]    in_mid [PORTS];
  logic [M-1:0]     lnk_a [NI];
  logic [M-1:0]     lnk_b [NO];

  // named internal events
  logic          accept, range_bad, srch_err;
  logic [PW-1:0] pin_s, pout_s;
  logic [AW-1:0] sa;
  logic [BW-1:0] sb;
  logic [M-1:0]  free_mask;
  logic [MW-1:0] pick, srch_mid;

  assign accept    = req_valid && (st_q == ST_IDLE);
  assign range_bad = (int'(pin_q) >= PORTS) || (int'(pout_q) >= PORTS);
  assign pin_s     = range_bad ? '0 : pin_q;
  assign pout_s    = range_bad ? '0 : pout_q;
  assign sa        = AW'(sw_of(int'(pin_s), N));
  assign sb        = BW'(sw_of(int'(pout_s), P));
  assign free_mask = ~lnk_a[sa] & ~lnk_b[sb];

  always_comb begin
    pick = '0;
    for (int m = M - 1; m >= 0; m--)
      if (free_mask[m]) pick = MW'(m);
  end

  always_comb begin
    if (kind_q == KIND_SETUP) begin
      srch_err = range_bad || in_busy[pin_s] || out_busy[pout_s] || (free_mask == '0);
      srch_mid = pick;
    end else begin
      srch_err = range_bad || !in_busy[pin_s] || (in_dst[pin_s] != pout_q);
      srch_mid = in_mid[pin_s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      kind_q    <= KIND_SETUP;
      pin_q     <= '0;
      pout_q    <= '0;
      res_err_q <= 1'b0;
      res_mid_q <= '0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_mid   <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          kind_q <= req_kind;
          pin_q  <= req_in;
          pout_q <= req_out;
          st_q   <= ST_SRCH;
        end
        ST_SRCH: begin
          res_err_q <= srch_err;
          res_mid_q <= srch_mid;
          st_q      <= ST_PROG;
        end
        default: begin
          rsp_done <= 1'b1;
          rsp_err  <= res_err_q;
          rsp_mid  <= res_mid_q;
          st_q     <= ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_busy  <= '0;
      out_busy <= '0;
      for (int i = 0; i < PORTS; i++) begin
        in_dst[i] <= '0;
        in_mid[i] <= '0;
      end
      for (int a = 0; a < NI; a++) lnk_a[a] <= '0;
      for (int b = 0; b < NO; b++) lnk_b[b] <= '0;
    end else if (prog_en) begin
      in_busy[pin_s]          <= prog_on;
      out_busy[pout_s]        <= prog_on;
      in_dst[pin_s]           <= pout_q;
      in_mid[pin_s]           <= res_mid_q;
      lnk_a[sa][res_mid_q]    <= prog_on;
      lnk_b[sb][res_mid_q]    <= prog_on;
    end
  end

  assign prog_en = (st_q == ST_PROG) && !res_err_q;
  assign prog_on = (kind_q == KIND_SETUP);
  assign prog_a  = sa;
  assign prog_b  = sb;
  assign prog_m  = res_mid_q;
  assign prog_li = LW'(loc_of(int'(pin_s), N));
  assign prog_lo = OW'(loc_of(int'(pout_s), P));

  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##2 rsp_done);

  // R5
  free_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SRCH && kind_q == KIND_SETUP && !range_bad &&
     !in_busy[pin_s] && !out_busy[pout_s]) |-> (free_mask != '0));

  // R6
  reject_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> (in_busy == $past(in_busy) && out_busy == $past(out_busy)));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && req_valid) |=> ($stable(pin_q) && $stable(pout_q)));

  for (genvar a = 0; a < NI; a++) begin : g_load
    // R5
    link_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lnk_a[a]) <= N);
  end

endmodule

// File: rtl/clos_switch.sv
module clos_switch
  import clos_pkg::*;
#(
  parameter int NI = 4,
  parameter int NO = 4,
  parameter int N  = 3,
  parameter int P  = 3,
  parameter int W  = 8,
  localparam int M     = N + P - 1,
  localparam int PORTS = NI * N,
  localparam int PW    = idx_w(PORTS),
  localparam int AW    = idx_w(NI),
  localparam int BW    = idx_w(NO),
  localparam int MW    = idx_w(M),
  localparam int LW    = idx_w(N),
  localparam int OW    = idx_w(P)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_kind,
  input  logic [PW-1:0]      req_in,
  input  logic [PW-1:0]      req_out,
  output logic               rsp_done,
  output logic               rsp_err,
  output logic [MW-1:0]      rsp_mid,
  input  logic [PORTS*W-1:0] in_data,
  input  logic [PORTS-1:0]   in_valid,
  output logic [PORTS*W-1:0] out_data,
  output logic [PORTS-1:0]   out_valid
);

  logic          prog_en, prog_on;
  logic [AW-1:0] prog_a;
  logic [BW-1:0] prog_b;
  logic [MW-1:0] prog_m;
  logic [LW-1:0] prog_li;
  logic [OW-1:0] prog_lo;

  clos_ctrl #(.NI(NI), .NO(NO), .N(N), .P(P), .M(M)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_in(req_in), .req_out(req_out),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_mid(rsp_mid),
    .prog_en(prog_en), .prog_on(prog_on), .prog_a(prog_a), .prog_b(prog_b),
    .prog_m(prog_m), .prog_li(prog_li), .prog_lo(prog_lo)
  );

  logic [M*W-1:0]  fst_d [NI];
  logic [M-1:0]    fst_v [NI];
  logic [NI*W-1:0] mid_in_d [M];
  logic [NI-1:0]   mid_in_v [M];
  logic [NO*W-1:0] mid_out_d [M];
  logic [NO-1:0]   mid_out_v [M];
  logic [M*W-1:0]  lst_in_d [NO];
  logic [M-1:0]    lst_in_v [NO];

  for (genvar a = 0; a < NI; a++) begin : g_first
    clos_xbar #(.NIN(N), .NOUT(M), .W(W)) u_sw (
      .clk(clk), .rst_n(rst_n),
      .wr_en(prog_en && prog_a == AW'(a)), .wr_port(prog_m), .wr_sel(prog_li), .wr_on(prog_on),
      .in_d(in_data[a*N*W +: N*W]), .in_v(in_valid[a*N +: N]),
      .out_d(fst_d[a]), .out_v(fst_v[a])
    );
    for (genvar m = 0; m < M; m++) begin : g_up
      assign mid_in_d[m][a*W +: W] = fst_d[a][m*W +: W];
      assign mid_in_v[m][a]        = fst_v[a][m];
    end
  end

  for (genvar m = 0; m < M; m++) begin : g_mid
    clos_xbar #(.NIN(NI), .NOUT(NO), .W(W)) u_sw (
      .clk(clk), .rst_n(rst_n),
      .wr_en(prog_en && prog_m == MW'(m)), .wr_port(prog_b), .wr_sel(prog_a), .wr_on(prog_on),
      .in_d(mid_in_d[m]), .in_v(mid_in_v[m]),
      .out_d(mid_out_d[m]), .out_v(mid_out_v[m])
    );
    for (genvar b = 0; b < NO; b++) begin : g_down
      assign lst_in_d[b][m*W +: W] = mid_out_d[m][b*W +: W];
      assign lst_in_v[b][m]        = mid_out_v[m][b];
    end
  end

  for (genvar b = 0; b < NO; b++) begin : g_last
    clos_xbar #(.NIN(M), .NOUT(P), .W(W)) u_sw (
      .clk(clk), .rst_n(rst_n),
      .wr_en(prog_en && prog_b == BW'(b)), .wr_port(prog_lo), .wr_sel(prog_m), .wr_on(prog_on),
      .in_d(lst_in_d[b]), .in_v(lst_in_v[b]),
      .out_d(out_data[b*P*W +: P*W]), .out_v(out_valid[b*P +: P])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (out_valid == '0 && !rsp_done));

endmodule

// File: tb/clos_switch_tb.sv
`timescale 1ns/1ps
module clos_switch_tb;
  localparam int PORTS = 12;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_kind = 0;
  logic [3:0] req_in = 0, req_out = 0;
  logic rsp_done, rsp_err;
  logic [2:0] rsp_mid;
  logic [PORTS*W-1:0] in_data = '0, out_data;
  logic [PORTS-1:0] in_valid = '0, out_valid;

  int total = 0, fails = 0;
  int m_dst [PORTS];
  int m_mid [PORTS];
  bit m_obusy [PORTS];
  bit la [4][5];
  bit lb [4][5];

  always #2.5 clk = ~clk;

  clos_switch u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_in(req_in), .req_out(req_out), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_mid(rsp_mid), .in_data(in_data), .in_valid(in_valid),
    .out_data(out_data), .out_valid(out_valid)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one request through the port; checks the response against the model
  task automatic req(input bit kind, input int pin, input int pout, input string tag);
    bit bad;
    int em;
    em = 0;
    if (kind == 0) begin
      bad = (pin >= PORTS) || (pout >= PORTS);
      if (!bad) bad = (m_dst[pin] >= 0) || m_obusy[pout];
      if (!bad) begin
        em = -1;
        for (int m = 4; m >= 0; m--)
          if (!la[pin/3][m] && !lb[pout/3][m]) em = m;
        if (em < 0) begin bad = 1; em = 0; end
      end
    end else begin
      bad = (pin >= PORTS) || (pout >= PORTS);
      if (!bad) bad = (m_dst[pin] != pout);
      if (!bad) em = m_mid[pin];
    end
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_in = 4'(pin); req_out = 4'(pout);
    @(negedge clk);
    req_valid = 0;
    @(posedge clk);
    #1 chk(rsp_done == 0, tag, "done early", int'(rsp_done), 0);
    @(posedge clk);
    #1;
    chk(rsp_done == 1, "R2", "done pulse", int'(rsp_done), 1);
    chk(rsp_err == bad, tag, "err flag", int'(rsp_err), int'(bad));
    if (!bad) begin
      if (kind == 0) chk(int'(rsp_mid) == em, "R4", "middle switch", int'(rsp_mid), em);
      if (kind == 0) begin
        m_dst[pin] = pout; m_mid[pin] = em; m_obusy[pout] = 1;
        la[pin/3][em] = 1; lb[pout/3][em] = 1;
      end else begin
        m_dst[pin] = -1; m_obusy[pout] = 0;
        la[pin/3][em] = 0; lb[pout/3][em] = 0;
      end
    end
    @(posedge clk);
    #1 chk(rsp_done == 0, "R2", "single pulse", int'(rsp_done), 0);
  endtask

  // drive a pattern and check every output against the model
  task automatic routes(input int salt, input string tag);
    @(negedge clk);
    for (int i = 0; i < PORTS; i++) begin
      in_data[i*W +: W] = 8'((salt * 16 + i * 7 + 3) & 255);
      in_valid[i] = ((i + salt) % 3) != 0;
    end
    #1;
    for (int k = 0; k < PORTS; k++) begin
      int src;
      int ed, ev;
      src = -1;
      for (int j = 0; j < PORTS; j++) if (m_dst[j] == k) src = j;
      ed = (src >= 0) ? int'(in_data[src*W +: W]) : 0;
      ev = (src >= 0) ? int'(in_valid[src]) : 0;
      chk(int'(out_data[k*W +: W]) == ed, (src >= 0) ? tag : "R9", "out data", int'(out_data[k*W +: W]), ed);
      chk(int'(out_valid[k]) == ev, (src >= 0) ? tag : "R9", "out valid", int'(out_valid[k]), ev);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < PORTS; i++) begin m_dst[i] = -1; m_mid[i] = 0; m_obusy[i] = 0; end
    for (int a = 0; a < 4; a++) for (int m = 0; m < 5; m++) begin la[a][m] = 0; lb[a][m] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    in_data = {PORTS{8'h5A}}; in_valid = '1;
    #1;
    chk(out_valid == '0, "R1", "valid in reset", int'(out_valid), 0);
    chk(out_data == '0, "R1", "data in reset", 0, 0);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_done == 0, "R1", "done after reset", int'(rsp_done), 0);
    routes(1, "R9");

    // R10: a second strobe during the search cycle is ignored
    @(negedge clk);
    req_valid = 1; req_kind = 0; req_in = 0; req_out = 5;
    @(negedge clk);
    req_in = 1; req_out = 6;
    @(negedge clk);
    req_valid = 0;
    @(posedge clk);
    #1 chk(rsp_done == 1 && rsp_err == 0, "R10", "first request done", int'(rsp_done), 1);
    m_dst[0] = 5; m_mid[0] = 0; m_obusy[5] = 1; la[0][0] = 1; lb[1][0] = 1;
    routes(2, "R10");
    req(1, 0, 5, "R7");
    routes(3, "R7");

    // R11: out-of-range ports
    req(0, 12, 3, "R11");
    req(0, 2, 15, "R11");
    req(1, 13, 0, "R11");

    for (int s = 1; s <= 12; s++) begin
      for (int i = 0; i < PORTS; i++) req(0, i, (i + s) % PORTS, "R5");
      routes(s, "R3");
      req(0, 0, (s + 4) % PORTS, "R6");
      req(1, 0, (s + 1) % PORTS, "R8");
      for (int i = 1; i < PORTS; i += 2) req(1, i, (i + s) % PORTS, "R7");
      routes(s + 20, "R7");
      for (int i = 1; i < PORTS; i += 2) req(0, i, (i + s + 6) % PORTS, "R5");
      routes(s + 40, "R5");
      for (int i = 0; i < PORTS; i++) if (m_dst[i] >= 0) req(1, i, m_dst[i], "R7");
      routes(s + 60, "R9");
      req(1, 3, 3, "R8");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule